// File: doc/BRIEF.md
# Speculative Critical-Section Conflict Tracker

This block lets a core run a lock-protected critical section without taking the lock. When the core signals the start of a section, the tracker asks for a register checkpoint and enters speculative mode. Every load and store in that mode marks the touched cache block with an access bit. Stores go into a small private write buffer, so other agents cannot see them. Each accepted store also issues a request for exclusive ownership of its block.

While speculative, the tracker watches incoming coherence requests. If another agent invalidates a marked block, or asks for exclusive access to one, the tracker aborts. It also aborts when a store arrives and the write buffer is full. An abort discards the buffered stores, clears every mark and pulses a checkpoint-restore request. If the section ends cleanly, the buffered stores are drained one per cycle. During the drain, coherence requests to marked blocks are stalled, so the whole group looks atomic to other agents. After a commit or an abort, all marks are cleared and the tracker returns to idle.

Top module: `lec_tracker`

## Requirements
- R1: After reset the tracker is idle and spec_active, ckpt_req, ckpt_restore, excl_req_valid, cmt_valid and snp_stall are all low.
- R2: sec_begin while idle makes spec_active high from the next cycle, and ckpt_req is high for exactly that one cycle. sec_begin in any other state has no effect.
- R3: While speculative, ld_valid or st_valid marks block ld_addr or st_addr. A later snoop with snp_kind 2'b01 (invalidate) to a marked block aborts the section.
- R4: While speculative, a snoop with snp_kind 2'b10 (exclusive request) to a marked block aborts the section. A snoop with snp_kind 2'b00 (shared read), or any snoop to an unmarked block, has no effect.
- R5: Each store accepted while speculative gives a one-cycle excl_req_valid pulse in the next cycle, with excl_req_addr equal to its address. cmt_valid stays low while speculative.
- R6: A store that arrives while DEPTH stores are already buffered aborts the section.
- R7: An abort drops spec_active and pulses ckpt_restore for one cycle, both in the next cycle. The buffered stores are discarded and every mark is cleared.
- R8: sec_end while speculative and without an abort moves to the drain. From the next cycle, cmt_valid is high for exactly N consecutive cycles, and cmt_addr and cmt_data follow the N buffered stores in arrival order. When N is 0 the tracker returns straight to idle.
- R9: During the drain, a snoop of any kind to a marked block raises snp_stall in the same cycle, combinationally, and never aborts.
- R10: After the drain completes, the tracker is idle and no block is marked.
- R11: An abort condition wins over sec_end in the same cycle. A store accepted in the same cycle as sec_end is part of the commit.
- R12: Loads, stores and snoops while idle, and loads and stores during the drain, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_begin | input | 1 | Start of critical section |
| sec_end | input | 1 | End of critical section |
| ld_valid | input | 1 | Load performed this cycle |
| ld_addr | input | ADDR_W | Block address of the load |
| st_valid | input | 1 | Store performed this cycle |
| st_addr | input | ADDR_W | Block address of the store |
| st_data | input | DATA_W | Store data |
| snp_valid | input | 1 | Incoming coherence request |
| snp_kind | input | 2 | 00 shared read, 01 invalidate, 10 exclusive request |
| snp_addr | input | ADDR_W | Block address of the coherence request |
| spec_active | output | 1 | Speculative mode is active |
| ckpt_req | output | 1 | Take a register checkpoint (pulse) |
| ckpt_restore | output | 1 | Restore the checkpoint after an abort (pulse) |
| excl_req_valid | output | 1 | Exclusive-ownership request (pulse) |
| excl_req_addr | output | ADDR_W | Block address of the ownership request |
| cmt_valid | output | 1 | A buffered store is being drained |
| cmt_addr | output | ADDR_W | Block address of the drained store |
| cmt_data | output | DATA_W | Data of the drained store |
| snp_stall | output | 1 | Hold off the current coherence request |

## Verification
ckpt_req, ckpt_restore, excl_req_valid, spec_active and the cmt_* signals all come from state registered at the edge that takes the stimulus, so they are due one cycle later. snp_stall depends only on the current snoop inputs and the marks, so it is due in the same cycle. The bench drives inputs at the falling edge and checks snp_stall 1 ns later, before the rising edge. It checks the registered results at the next falling edge against a cycle model built from the requirements. Each abort, commit, ignored input and stall is tagged with the requirement it exercises.

// File: rtl/lec_pkg.sv
package lec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SPEC   = 2'd1,
        ST_COMMIT = 2'd2
    } lec_state_e;

    localparam logic [1:0] SNP_SHARED = 2'b00;
    localparam logic [1:0] SNP_INVAL  = 2'b01;
    localparam logic [1:0] SNP_EXCL   = 2'b10;
endpackage

// File: rtl/lec_access_map.sv
module lec_access_map #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              mark_a,
    input  logic [ADDR_W-1:0] mark_a_addr,
    input  logic              mark_b,
    input  logic [ADDR_W-1:0] mark_b_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit
);
    localparam int NBLK = 1 << ADDR_W;

    logic [NBLK-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (clr) begin
            bits_d = '0;
        end else begin
            if (mark_a) bits_d[mark_a_addr] = 1'b1;
            if (mark_b) bits_d[mark_b_addr] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign probe_hit = bits_q[probe_addr];
endmodule

// File: rtl/lec_wbuf.sv
module lec_wbuf #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push,
    input  logic [$clog2(DEPTH)-1:0] push_idx,
    input  logic [ADDR_W-1:0]        push_addr,
    input  logic [DATA_W-1:0]        push_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    logic [DEPTH-1:0][ADDR_W-1:0] addr_d, addr_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_d, data_q;

    always_comb begin
        addr_d = addr_q;
        data_d = data_q;
        if (push) begin
            addr_d[push_idx] = push_addr;
            data_d[push_idx] = push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

    assign rd_addr = addr_q[rd_idx];
    assign rd_data = data_q[rd_idx];
endmodule

// File: rtl/lec_tracker.sv
module lec_tracker
    import lec_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_begin,
    input  logic              sec_end,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    input  logic              snp_valid,
    input  logic [1:0]        snp_kind,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              spec_active,
    output logic              ckpt_req,
    output logic              ckpt_restore,
    output logic              excl_req_valid,
    output logic [ADDR_W-1:0] excl_req_addr,
    output logic              cmt_valid,
    output logic [ADDR_W-1:0] cmt_addr,
    output logic [DATA_W-1:0] cmt_data,
    output logic              snp_stall
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        lec_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rd;
        logic              ckpt;
        logic              rest;
        logic              xv;
        logic [ADDR_W-1:0] xa;
    } ctl_t;

    ctl_t r_d, r_q;

    logic snp_hit, conflict, overflow;
    logic mark_ld, mark_st, do_push, do_clr;
    logic [CNT_W-1:0] cnt_after;

    lec_access_map #(.ADDR_W(ADDR_W)) u_map (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (do_clr),
        .mark_a      (mark_ld),
        .mark_a_addr (ld_addr),
        .mark_b      (mark_st),
        .mark_b_addr (st_addr),
        .probe_addr  (snp_addr),
        .probe_hit   (snp_hit)
    );

    lec_wbuf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_idx  (r_q.cnt[IDX_W-1:0]),
        .push_addr (st_addr),
        .push_data (st_data),
        .rd_idx    (r_q.rd[IDX_W-1:0]),
        .rd_addr   (cmt_addr),
        .rd_data   (cmt_data)
    );

    assign conflict = snp_valid && snp_hit &&
                      (snp_kind == SNP_INVAL || snp_kind == SNP_EXCL);
    assign overflow = st_valid && (r_q.cnt == CNT_W'(DEPTH));

    always_comb begin
        r_d       = r_q;
        r_d.ckpt  = 1'b0;
        r_d.rest  = 1'b0;
        r_d.xv    = 1'b0;
        mark_ld   = 1'b0;
        mark_st   = 1'b0;
        do_push   = 1'b0;
        do_clr    = 1'b0;
        cnt_after = r_q.cnt;
        unique case (r_q.st)
            ST_IDLE: begin
                if (sec_begin) begin
                    r_d.st   = ST_SPEC;
                    r_d.ckpt = 1'b1;
                    r_d.cnt  = '0;
                end
            end
            ST_SPEC: begin
                if (conflict || overflow) begin
                    r_d.st   = ST_IDLE;
                    r_d.rest = 1'b1;
                    r_d.cnt  = '0;
                    do_clr   = 1'b1;
                end else begin
                    mark_ld = ld_valid;
                    if (st_valid) begin
                        mark_st   = 1'b1;
                        do_push   = 1'b1;
                        cnt_after = r_q.cnt + 1'b1;
                        r_d.xv    = 1'b1;
                        r_d.xa    = st_addr;
                    end
                    r_d.cnt = cnt_after;
                    if (sec_end) begin
                        r_d.rd = '0;
                        if (cnt_after == '0) begin
                            r_d.st = ST_IDLE;
                            do_clr = 1'b1;
                        end else begin
                            r_d.st = ST_COMMIT;
                        end
                    end
                end
            end
            ST_COMMIT: begin
                r_d.rd = r_q.rd + 1'b1;
                if (r_q.rd == r_q.cnt - 1'b1) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                    r_d.rd  = '0;
                    do_clr  = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, rd: '0, ckpt: 1'b0,
                     rest: 1'b0, xv: 1'b0, xa: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign spec_active    = (r_q.st == ST_SPEC);
    assign cmt_valid      = (r_q.st == ST_COMMIT);
    assign ckpt_req       = r_q.ckpt;
    assign ckpt_restore   = r_q.rest;
    assign excl_req_valid = r_q.xv;
    assign excl_req_addr  = r_q.xa;
    assign snp_stall      = cmt_valid && snp_valid && snp_hit;
endmodule

// File: rtl/lec_tracker_chk.sv
module lec_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic sec_begin,
    input logic sec_end,
    input logic st_valid,
    input logic spec_active,
    input logic ckpt_req,
    input logic ckpt_restore,
    input logic excl_req_valid,
    input logic cmt_valid,
    input logic snp_stall
);
    // R2: a checkpoint request only follows a section start
    a_r2_ckpt_after_begin: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_req |-> ($past(sec_begin) && spec_active));

    // R5: an ownership request only follows a store
    a_r5_excl_after_store: assert property (@(posedge clk) disable iff (!rst_n)
        excl_req_valid |-> $past(st_valid));

    // R7: a restore leaves neither speculation nor drain running
    a_r7_restore_exits: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_restore |-> (!spec_active && !cmt_valid));

    // R8: a drain starts only from a section end while speculative
    a_r8_drain_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmt_valid) |-> ($past(spec_active) && $past(sec_end)));

    // R9: stalls happen only during the drain
    a_r9_stall_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
        snp_stall |-> cmt_valid);

    // R1: speculative and drain states are exclusive
    a_r1_state_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({spec_active, cmt_valid}));
endmodule

bind lec_tracker lec_tracker_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sec_begin      (sec_begin),
    .sec_end        (sec_end),
    .st_valid       (st_valid),
    .spec_active    (spec_active),
    .ckpt_req       (ckpt_req),
    .ckpt_restore   (ckpt_restore),
    .excl_req_valid (excl_req_valid),
    .cmt_valid      (cmt_valid),
    .snp_stall      (snp_stall)
);

// File: tb/tb_lec_tracker.sv
module tb_lec_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 4;
    localparam int NBLK   = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n;
    logic sec_begin, sec_end, ld_valid, st_valid, snp_valid;
    logic [ADDR_W-1:0] ld_addr, st_addr, snp_addr;
    logic [DATA_W-1:0] st_data;
    logic [1:0] snp_kind;
    logic spec_active, ckpt_req, ckpt_restore, excl_req_valid, cmt_valid, snp_stall;
    logic [ADDR_W-1:0] excl_req_addr, cmt_addr;
    logic [DATA_W-1:0] cmt_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    lec_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .sec_begin(sec_begin), .sec_end(sec_end),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .st_valid(st_valid),
        .st_addr(st_addr), .st_data(st_data), .snp_valid(snp_valid),
        .snp_kind(snp_kind), .snp_addr(snp_addr), .spec_active(spec_active),
        .ckpt_req(ckpt_req), .ckpt_restore(ckpt_restore),
        .excl_req_valid(excl_req_valid), .excl_req_addr(excl_req_addr),
        .cmt_valid(cmt_valid), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
        .snp_stall(snp_stall)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // bench model, built from the requirements
    int              m_st = 0;          // 0 idle, 1 speculative, 2 drain
    bit [NBLK-1:0]   m_acc;
    bit [ADDR_W-1:0] m_qa [DEPTH];
    bit [DATA_W-1:0] m_qd [DEPTH];
    int              m_cnt = 0;
    int              m_rd  = 0;
    bit              e_ckpt, e_rest, e_xv;
    bit [ADDR_W-1:0] e_xa;
    string           e_tag = "R1";

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: registered checks, drive, combinational checks, model step
    task automatic cyc(bit b, bit e, bit lv, bit [ADDR_W-1:0] la,
                       bit sv, bit [ADDR_W-1:0] sa, bit [DATA_W-1:0] sd,
                       bit nv, bit [1:0] nk, bit [ADDR_W-1:0] na);
        bit conf, ovf;
        @(negedge clk);
        check({e_tag, " spec_active"}, spec_active, m_st == 1);
        check("R2 ckpt_req", ckpt_req, e_ckpt);
        check("R7 ckpt_restore", ckpt_restore, e_rest);
        check("R5 excl_req_valid", excl_req_valid, e_xv);
        if (e_xv) check("R5 excl_req_addr", excl_req_addr, e_xa);
        sec_begin = b; sec_end = e; ld_valid = lv; ld_addr = la;
        st_valid = sv; st_addr = sa; st_data = sd;
        snp_valid = nv; snp_kind = nk; snp_addr = na;
        #1;
        check("R8 cmt_valid", cmt_valid, m_st == 2);
        if (m_st == 2) begin
            check("R8 cmt_addr", cmt_addr, m_qa[m_rd]);
            check("R8 cmt_data", cmt_data, m_qd[m_rd]);
        end
        check("R9 snp_stall", snp_stall, (m_st == 2) && nv && m_acc[na]);
        e_ckpt = 0; e_rest = 0; e_xv = 0;
        e_tag = (m_st == 0 && (lv || sv || nv)) ? "R12" : "R3";
        case (m_st)
            0: if (b) begin m_st = 1; e_ckpt = 1; m_cnt = 0; e_tag = "R2"; end
            1: begin
                conf = nv && m_acc[na] && (nk == 2'b01 || nk == 2'b10);
                ovf  = sv && (m_cnt == DEPTH);
                if (conf || ovf) begin
                    e_tag = ovf ? "R6" : (nk == 2'b10 ? "R4" : "R3");
                    if (e) e_tag = "R11";
                    m_st = 0; e_rest = 1; m_cnt = 0; m_acc = '0;
                end else begin
                    if (nv) e_tag = "R4";
                    if (lv) m_acc[la] = 1'b1;
                    if (sv) begin
                        m_acc[sa] = 1'b1; m_qa[m_cnt] = sa; m_qd[m_cnt] = sd;
                        m_cnt++; e_xv = 1; e_xa = sa;
                    end
                    if (e) begin
                        e_tag = "R11"; m_rd = 0;
                        if (m_cnt == 0) begin m_st = 0; m_acc = '0; end
                        else m_st = 2;
                    end
                end
            end
            default: begin
                e_tag = "R10";
                if (m_rd == m_cnt - 1) begin
                    m_st = 0; m_cnt = 0; m_rd = 0; m_acc = '0;
                end else m_rd++;
            end
        endcase
    endtask

    task automatic idle_cyc();
        cyc(0, 0, 0, '0, 0, '0, '0, 0, 2'b00, '0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd7741));
        m_acc = '0;
        rst_n = 0;
        {sec_begin, sec_end, ld_valid, st_valid, snp_valid} = '0;
        ld_addr = '0; st_addr = '0; st_data = '0; snp_kind = '0; snp_addr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset state
        check("R1 spec_active", spec_active, 0);
        check("R1 ckpt_req", ckpt_req, 0);
        check("R1 ckpt_restore", ckpt_restore, 0);
        check("R1 excl_req_valid", excl_req_valid, 0);
        check("R1 cmt_valid", cmt_valid, 0);
        check("R1 snp_stall", snp_stall, 0);
        // R12: traffic while idle, then an empty section commits straight to idle
        cyc(0, 0, 1, 6'd3, 1, 6'd3, 16'h1111, 1, 2'b01, 6'd3);
        cyc(1, 0, 0, '0, 0, '0, '0, 0, 2'b00, '0);
        cyc(0, 1, 0, '0, 0, '0, '0, 1, 2'b01, 6'd3);
        idle_cyc();
        // R6: overflow of the write buffer
        cyc(1, 0, 0, '0, 0, '0, '0, 0, 2'b00, '0);
        for (int i = 0; i < DEPTH + 1; i++)
            cyc(0, 0, 0, '0, 1, 6'(i + 10), 16'(i + 16'hA0), 0, 2'b00, '0);
        idle_cyc();
        // R4 shared read ignored, R9 stall during drain, R11 store at end
        cyc(1, 0, 0, '0, 0, '0, '0, 0, 2'b00, '0);
        cyc(0, 0, 1, 6'd20, 1, 6'd21, 16'hBEEF, 0, 2'b00, '0);
        cyc(0, 0, 0, '0, 0, '0, '0, 1, 2'b00, 6'd20);
        cyc(0, 1, 0, '0, 1, 6'd22, 16'hCAFE, 0, 2'b00, '0);
        cyc(0, 0, 1, 6'd30, 1, 6'd30, 16'h0, 1, 2'b01, 6'd21);
        cyc(0, 0, 0, '0, 0, '0, '0, 1, 2'b10, 6'd20);
        idle_cyc();
        // R10: marks gone after commit
        cyc(1, 0, 0, '0, 0, '0, '0, 0, 2'b00, '0);
        cyc(0, 0, 0, '0, 0, '0, '0, 1, 2'b01, 6'd21);
        // R4/R11: exclusive snoop conflicts with section end
        cyc(0, 0, 1, 6'd40, 0, '0, '0, 0, 2'b00, '0);
        cyc(0, 1, 0, '0, 0, '0, '0, 1, 2'b10, 6'd40);
        idle_cyc();
        // random phase
        for (int i = 0; i < 3000; i++) begin
            bit b, e, lv, sv, nv;
            b  = ($urandom % 4) == 0;
            e  = ($urandom % 8) == 0;
            lv = ($urandom % 3) == 0;
            sv = ($urandom % 3) == 0;
            nv = ($urandom % 5) == 0;
            cyc(b, e, lv, 6'($urandom % 8), sv, 6'($urandom % 8),
                16'($urandom), nv, 2'($urandom % 3), 6'($urandom % 8));
        end
        idle_cyc();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule